// File: doc/BRIEF.md
# STS-1 Payload Pointer Generator

This block produces the payload pointer bytes (H1, H2) and the pointer action byte (H3) of an outbound STS-1 stream, one set per frame. A frame-start strobe tells it when to commit the bytes for the next frame. It keeps the active 10-bit pointer, which is seeded from an input while reset is asserted. Between strobes it holds the bytes steady for the overhead inserter.

Several register-style controls act on top of normal generation. Request pulses force a positive or a negative pointer adjustment. The spacing rule between adjustments is enforced inside the block. A self-clearing request sends one New Data Flag frame that jumps to an arbitrary pointer value. A level input holds the New Data Flag on every frame. Two flags tell the payload mapper whether the H3 slot carries a payload byte, or whether the byte after H3 is a stuff byte.

Top module: `sts1_ptr_gen`

## Requirements
- R1: While `rst_n` is low, the block clears all outputs to zero and clears `ndf_pending` and any stuff request. It loads `seed_ptr` as the active pointer and arms the spacing counter so that a stuff request may act on the first frame.
- R2: On each rising edge with `frame_sof` high, a normal frame registers H1 = {4'b0110, 2'b00, ptr[9:8]} and H2 = ptr[7:0], where ptr is the active pointer. The outputs hold their values until the next strobe.
- R3: A positive stuff frame sends the active pointer with its I-bits (bits 9, 7, 5, 3, 1) inverted and raises `stuff_after_h3` for that frame. The active pointer then becomes ptr+1, and 782 wraps to 0.
- R4: A negative stuff frame sends the active pointer with its D-bits (bits 8, 6, 4, 2, 0) inverted and raises `h3_carries_data` for that frame. The active pointer then becomes ptr-1, and 0 wraps to 782.
- R5: A pending stuff request acts only on a strobe that follows at least 3 normal frames since the last pointer adjustment (stuff or New Data Flag). Until then it stays pending.
- R6: There is one stuff slot. A request that arrives while the slot is occupied is dropped, including in the cycle in which the slot is consumed. If increment and decrement arrive together into an empty slot, the increment wins.
- R7: A pending single New Data Flag request makes the next frame carry N = 4'b1001 and pointer bits equal to `arb_ptr`. That value becomes the active pointer, and later frames return to N = 4'b0110. A New Data Flag frame takes priority over a pending stuff, which stays pending.
- R8: A pulse on `ndf_single_set` raises `ndf_pending` on the next cycle. The bit clears itself on the strobe that sends the New Data Flag frame.
- R9: While `ndf_hold` is high, every frame is a New Data Flag frame that loads `arb_ptr`. Stuff requests accepted in this time stay pending.
- R10: `h3_byte` equals `h3_payload` while `h3_carries_data` is high and is 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_ptr | input | 10 | Pointer loaded while in reset |
| frame_sof | input | 1 | One-cycle strobe per frame; commits the next frame's bytes |
| stuff_inc_req | input | 1 | Request pulse for a positive stuff |
| stuff_dec_req | input | 1 | Request pulse for a negative stuff |
| ndf_single_set | input | 1 | Write pulse that sets the single New Data Flag request |
| ndf_hold | input | 1 | Level: New Data Flag on every frame |
| arb_ptr | input | 10 | Arbitrary pointer used by New Data Flag frames |
| h3_payload | input | 8 | Payload byte from the mapper for the H3 slot |
| h1_byte | output | 8 | H1 byte for the current frame |
| h2_byte | output | 8 | H2 byte for the current frame |
| h3_byte | output | 8 | H3 byte: payload or 8'h00 |
| h3_carries_data | output | 1 | H3 slot carries payload this frame |
| stuff_after_h3 | output | 1 | Byte following H3 is a stuff byte this frame |
| ndf_pending | output | 1 | Self-clearing single New Data Flag request bit |

## Verification
The frame bytes and both flags come from a single register stage. They change on the rising edge that samples `frame_sof` and stay fixed until the next strobe. The bench therefore raises the strobe for one cycle and samples on the falling edge that follows. Control pulses are applied two cycles before each strobe, so `ndf_pending` is visible one cycle after its pulse, and the effect of a pulse on the pointer appears in the bytes of the next strobe. `h3_byte` follows `h3_payload` with no delay while the data flag is set, so it is checked in the same sample.

// File: rtl/sts1_ptr_pkg.sv
package sts1_ptr_pkg;

    parameter int PTR_W      = 10;
    parameter int PTR_MAX    = 782;
    parameter int GAP_FRAMES = 3;
    localparam int GAP_W     = $clog2(GAP_FRAMES + 1);

    localparam logic [3:0] N_NORMAL = 4'b0110;
    localparam logic [3:0] N_NEWDAT = 4'b1001;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;        // active pointer
        logic [GAP_W-1:0] gap;        // normal frames since last adjustment (saturating)
        logic             stf_vld;    // stuff slot occupied
        logic             stf_dec;    // stuff slot direction: 1 = decrement
        logic             ndf_pend;   // single NDF request bit
        logic [7:0]       h1;
        logic [7:0]       h2;
        logic             h3_data;
        logic             post_stuff;
    } gen_state_t;

endpackage

// File: rtl/sts1_ptr_step.sv
module sts1_ptr_step #(
    parameter int PTR_W    = 10,
    parameter int PTR_MAX  = 782,
    parameter bit STEP_DOWN = 1'b0
) (
    input  logic [PTR_W-1:0] cur_ptr,
    output logic [PTR_W-1:0] nxt_ptr
);
    localparam logic [PTR_W-1:0] TOP = PTR_W'(PTR_MAX);

    generate
        if (STEP_DOWN) begin : g_down
            always_comb begin
                if (cur_ptr == '0) nxt_ptr = TOP;
                else               nxt_ptr = cur_ptr - PTR_W'(1);
            end
        end else begin : g_up
            always_comb begin
                if (cur_ptr >= TOP) nxt_ptr = '0;
                else                nxt_ptr = cur_ptr + PTR_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/sts1_ptr_pack.sv
module sts1_ptr_pack #(
    parameter int PTR_W = 10
) (
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             new_data,
    input  logic             flip_inc,
    input  logic             flip_dec,
    output logic [7:0]       h1_out,
    output logic [7:0]       h2_out
);
    import sts1_ptr_pkg::*;

    logic [PTR_W-1:0] inc_mask;
    logic [PTR_W-1:0] dec_mask;
    logic [PTR_W-1:0] sent_ptr;

    // Increment bits sit on odd positions (starting at the MSB), decrement bits on even.
    genvar b;
    generate
        for (b = 0; b < PTR_W; b++) begin : g_mask
            assign inc_mask[b] = ((PTR_W - 1 - b) % 2) == 0;
            assign dec_mask[b] = ((PTR_W - 1 - b) % 2) == 1;
        end
    endgenerate

    always_comb begin
        sent_ptr = ptr_val;
        if (flip_inc) sent_ptr = sent_ptr ^ inc_mask;
        if (flip_dec) sent_ptr = sent_ptr ^ dec_mask;
        h1_out = {(new_data ? N_NEWDAT : N_NORMAL), 2'b00, sent_ptr[PTR_W-1 -: 2]};
        h2_out = sent_ptr[7:0];
    end
endmodule

// File: rtl/sts1_ptr_gen.sv
module sts1_ptr_gen
    import sts1_ptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] seed_ptr,
    input  logic             frame_sof,
    input  logic             stuff_inc_req,
    input  logic             stuff_dec_req,
    input  logic             ndf_single_set,
    input  logic             ndf_hold,
    input  logic [PTR_W-1:0] arb_ptr,
    input  logic [7:0]       h3_payload,
    output logic [7:0]       h1_byte,
    output logic [7:0]       h2_byte,
    output logic [7:0]       h3_byte,
    output logic             h3_carries_data,
    output logic             stuff_after_h3,
    output logic             ndf_pending
);
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(GAP_FRAMES);

    gen_state_t st_q, st_d;

    logic             ndf_go, inc_go, dec_go, stf_ready;
    logic [PTR_W-1:0] ptr_up, ptr_dn, ptr_sent;
    logic [7:0]       h1_nx, h2_nx;

    sts1_ptr_step #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX), .STEP_DOWN(1'b0)) u_up (
        .cur_ptr (st_q.ptr),
        .nxt_ptr (ptr_up)
    );

    sts1_ptr_step #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX), .STEP_DOWN(1'b1)) u_dn (
        .cur_ptr (st_q.ptr),
        .nxt_ptr (ptr_dn)
    );

    assign ptr_sent = ndf_go ? arb_ptr : st_q.ptr;

    sts1_ptr_pack #(.PTR_W(PTR_W)) u_pack (
        .ptr_val  (ptr_sent),
        .new_data (ndf_go),
        .flip_inc (inc_go),
        .flip_dec (dec_go),
        .h1_out   (h1_nx),
        .h2_out   (h2_nx)
    );

    always_comb begin
        st_d      = st_q;
        ndf_go    = frame_sof && (ndf_hold || st_q.ndf_pend);
        stf_ready = st_q.stf_vld && (st_q.gap == GAP_FULL);
        inc_go    = frame_sof && !ndf_go && stf_ready && !st_q.stf_dec;
        dec_go    = frame_sof && !ndf_go && stf_ready &&  st_q.stf_dec;

        // self-clearing single NDF request
        st_d.ndf_pend = ndf_single_set || (st_q.ndf_pend && !ndf_go);

        // single stuff slot
        if (inc_go || dec_go) begin
            st_d.stf_vld = 1'b0;
        end else if (!st_q.stf_vld && (stuff_inc_req || stuff_dec_req)) begin
            st_d.stf_vld = 1'b1;
            st_d.stf_dec = !stuff_inc_req;
        end

        if (frame_sof) begin
            st_d.h1         = h1_nx;
            st_d.h2         = h2_nx;
            st_d.h3_data    = dec_go;
            st_d.post_stuff = inc_go;
            if (ndf_go)      st_d.ptr = arb_ptr;
            else if (inc_go) st_d.ptr = ptr_up;
            else if (dec_go) st_d.ptr = ptr_dn;
            if (ndf_go || inc_go || dec_go) st_d.gap = '0;
            else if (st_q.gap != GAP_FULL)  st_d.gap = st_q.gap + GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.ptr        <= seed_ptr;
            st_q.gap        <= GAP_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign h1_byte         = st_q.h1;
    assign h2_byte         = st_q.h2;
    assign h3_carries_data = st_q.h3_data;
    assign stuff_after_h3  = st_q.post_stuff;
    assign h3_byte         = st_q.h3_data ? h3_payload : 8'h00;
    assign ndf_pending     = st_q.ndf_pend;

endmodule

// File: rtl/sts1_ptr_gen_chk.sv
module sts1_ptr_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_sof,
    input logic       ndf_single_set,
    input logic       ndf_hold,
    input logic [7:0] h1_byte,
    input logic [7:0] h2_byte,
    input logic       h3_carries_data,
    input logic       stuff_after_h3,
    input logic       ndf_pending
);
    // R2
    nbits_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h1_byte == 8'h00) || (h1_byte[7:4] == 4'b0110) || (h1_byte[7:4] == 4'b1001));

    // R2
    ss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h1_byte[3:2] == 2'b00);

    // R2
    bytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sof |=> $stable({h1_byte, h2_byte, h3_carries_data, stuff_after_h3}));

    // R3
    stuff_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(h3_carries_data && stuff_after_h3));

    // R8
    ndf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ndf_single_set |=> ndf_pending);

    // R8
    ndf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ndf_pending) |-> $past(frame_sof));

    // R9
    ndf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sof && ndf_hold) |=> (h1_byte[7:4] == 4'b1001 && !h3_carries_data && !stuff_after_h3));
endmodule

bind sts1_ptr_gen sts1_ptr_gen_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_sof       (frame_sof),
    .ndf_single_set  (ndf_single_set),
    .ndf_hold        (ndf_hold),
    .h1_byte         (h1_byte),
    .h2_byte         (h2_byte),
    .h3_carries_data (h3_carries_data),
    .stuff_after_h3  (stuff_after_h3),
    .ndf_pending     (ndf_pending)
);

// File: tb/tb_sts1_ptr_gen.sv
module tb_sts1_ptr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] seed_ptr = 10'd780;
    logic       frame_sof = 1'b0;
    logic       stuff_inc_req = 1'b0;
    logic       stuff_dec_req = 1'b0;
    logic       ndf_single_set = 1'b0;
    logic       ndf_hold = 1'b0;
    logic [9:0] arb_ptr = '0;
    logic [7:0] h3_payload = 8'hA5;
    logic [7:0] h1_byte, h2_byte, h3_byte;
    logic       h3_carries_data, stuff_after_h3, ndf_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sts1_ptr_gen dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .seed_ptr        (seed_ptr),
        .frame_sof       (frame_sof),
        .stuff_inc_req   (stuff_inc_req),
        .stuff_dec_req   (stuff_dec_req),
        .ndf_single_set  (ndf_single_set),
        .ndf_hold        (ndf_hold),
        .arb_ptr         (arb_ptr),
        .h3_payload      (h3_payload),
        .h1_byte         (h1_byte),
        .h2_byte         (h2_byte),
        .h3_byte         (h3_byte),
        .h3_carries_data (h3_carries_data),
        .stuff_after_h3  (stuff_after_h3),
        .ndf_pending     (ndf_pending)
    );

    // {inc, dec, ndf_set, hold, arb[9:0], exp_h1, exp_h2, exp_h3data, exp_stuff}
    localparam int NV = 28;
    localparam logic [31:0] VEC [NV] = '{
        {4'b0000, 10'd0, 8'h63, 8'h0C, 2'b00},  // 0  R2 normal at 780
        {4'b1000, 10'd0, 8'h61, 8'hA6, 2'b01},  // 1  R3 inc acts at once after reset
        {4'b0000, 10'd0, 8'h63, 8'h0D, 2'b00},  // 2  R3 pointer now 781
        {4'b0100, 10'd0, 8'h63, 8'h0D, 2'b00},  // 3  R5 dec held
        {4'b0000, 10'd0, 8'h63, 8'h0D, 2'b00},  // 4  R5 still held
        {4'b0000, 10'd0, 8'h62, 8'h58, 2'b10},  // 5  R4 dec after 3 normals
        {4'b1000, 10'd0, 8'h63, 8'h0C, 2'b00},  // 6  R5 inc held
        {4'b0100, 10'd0, 8'h63, 8'h0C, 2'b00},  // 7  R6 dec dropped
        {4'b0000, 10'd0, 8'h63, 8'h0C, 2'b00},  // 8
        {4'b0000, 10'd0, 8'h61, 8'hA6, 2'b01},  // 9  R3
        {4'b0000, 10'd0, 8'h63, 8'h0D, 2'b00},  // 10
        {4'b0000, 10'd0, 8'h63, 8'h0D, 2'b00},  // 11
        {4'b0000, 10'd0, 8'h63, 8'h0D, 2'b00},  // 12
        {4'b0000, 10'd0, 8'h63, 8'h0D, 2'b00},  // 13 R6 dropped dec never acts
        {4'b1000, 10'd0, 8'h61, 8'hA7, 2'b01},  // 14 R3
        {4'b0000, 10'd0, 8'h63, 8'h0E, 2'b00},  // 15 pointer 782
        {4'b0000, 10'd0, 8'h63, 8'h0E, 2'b00},  // 16
        {4'b0000, 10'd0, 8'h63, 8'h0E, 2'b00},  // 17
        {4'b1000, 10'd0, 8'h61, 8'hA4, 2'b01},  // 18 R3 wrap 782 -> 0
        {4'b0010, 10'd5, 8'h90, 8'h05, 2'b00},  // 19 R7 single NDF
        {4'b0000, 10'd5, 8'h60, 8'h05, 2'b00},  // 20 R7 back to normal at 5
        {4'b0001, 10'd0, 8'h90, 8'h00, 2'b00},  // 21 R9 hold
        {4'b0101, 10'd0, 8'h90, 8'h00, 2'b00},  // 22 R9 dec stays pending
        {4'b0000, 10'd0, 8'h60, 8'h00, 2'b00},  // 23
        {4'b0000, 10'd0, 8'h60, 8'h00, 2'b00},  // 24
        {4'b0000, 10'd0, 8'h60, 8'h00, 2'b00},  // 25
        {4'b0000, 10'd0, 8'h61, 8'h55, 2'b10},  // 26 R4 dec at 0
        {4'b0000, 10'd0, 8'h63, 8'h0E, 2'b00}   // 27 R4 wrap 0 -> 782
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic inc, input logic dec, input logic nset,
                             input logic hold, input logic [9:0] arb);
        @(negedge clk);
        stuff_inc_req  = inc;
        stuff_dec_req  = dec;
        ndf_single_set = nset;
        ndf_hold       = hold;
        arb_ptr        = arb;
        @(negedge clk);
        stuff_inc_req  = 1'b0;
        stuff_dec_req  = 1'b0;
        ndf_single_set = 1'b0;
        @(negedge clk);
        frame_sof = 1'b1;
        @(negedge clk);
        frame_sof = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 h1", {24'h0, h1_byte}, 32'h0);
        chk("R1 flags", {29'h0, h3_carries_data, stuff_after_h3, ndf_pending}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            run_frame(v[31], v[30], v[29], v[28], v[27:18]);
            chk($sformatf("R2/R3/R4/R7 h1 vec%0d", i), {24'h0, h1_byte}, {24'h0, v[17:10]});
            chk($sformatf("R2/R3/R4/R7 h2 vec%0d", i), {24'h0, h2_byte}, {24'h0, v[9:2]});
            chk($sformatf("R3/R4 flags vec%0d", i),
                {30'h0, h3_carries_data, stuff_after_h3}, {30'h0, v[1:0]});
            chk($sformatf("R10 h3 vec%0d", i), {24'h0, h3_byte}, {24'h0, (v[1] ? 8'hA5 : 8'h00)});
            chk($sformatf("R8 pending vec%0d", i), {31'h0, ndf_pending}, 32'h0);
        end
        ndf_hold = 1'b0;

        // R6 simultaneous requests into empty slot: increment wins (pointer 782, gap 1)
        run_frame(1'b1, 1'b1, 1'b0, 1'b0, 10'd0);
        chk("R6 held frame1", {24'h0, h1_byte}, 32'h63);
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 10'd0);
        chk("R6 held frame2", {24'h0, h1_byte}, 32'h63);
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 10'd0);
        chk("R6 inc wins h1", {24'h0, h1_byte}, 32'h61);
        chk("R6 inc wins h2", {24'h0, h2_byte}, 32'hA4);
        chk("R6 inc wins flag", {31'h0, stuff_after_h3}, 32'h1);

        // R8 self-clearing bit seen before and after the strobe
        @(negedge clk);
        arb_ptr = 10'd300;
        ndf_single_set = 1'b1;
        @(negedge clk);
        ndf_single_set = 1'b0;
        chk("R8 set", {31'h0, ndf_pending}, 32'h1);
        @(negedge clk);
        chk("R8 held until strobe", {31'h0, ndf_pending}, 32'h1);
        frame_sof = 1'b1;
        @(negedge clk);
        frame_sof = 1'b0;
        chk("R8 cleared", {31'h0, ndf_pending}, 32'h0);
        chk("R7 ndf h1", {24'h0, h1_byte}, 32'h91);
        chk("R7 ndf h2", {24'h0, h2_byte}, 32'h2C);
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 10'd0);
        chk("R7 loaded pointer kept", {16'h0, h1_byte, h2_byte}, 32'h612C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule